// File: doc/BRIEF.md
# Multi-Mode I/Q Sample Assembler

This block sits between an external baseband data source and an interpolation and modulation datapath. It takes words from one shared input port and builds complete samples from them, each an in-phase word and a quadrature word. The port is read in one of three ways, chosen by a mode input:

- **Quadrature mode:** I and Q words alternate on the parallel bus.
- **Real mode:** each parallel word is a complete real sample.
- **Serial mode:** two pins of the port carry independent 16-bit bit streams, one for I and one for Q.

The block divides the system clock to make a data-clock enable and a data-clock output for the source. The divisor depends on the mode, on a programmable rate value R and on a rate-control bit. A transmit-enable input frames the stream. A transfer is taken only on cycles where the data-clock enable is high. Each finished sample appears on the I and Q outputs together with a single-cycle valid strobe. The outputs keep their value until the next sample is finished.

Top module: `iqAssembler`

## Requirements
- R1: While reset is held, sampleValid is 0 and iOut and qOut are 0.
- R2: The mode encoding is 00 for quadrature, 01 for real, 10 for serial, and 11 for quadrature. In quadrature mode with rateCtl low, dataClkEn is high for one cycle in every 2R system clock cycles. A rate value of 0 is treated as 1.
- R3: In quadrature mode with rateCtl high, dataClkEn repeats every 4R cycles. In real mode it repeats every 4R cycles whatever the value of rateCtl.
- R4: In serial mode, dataClkEn repeats every R cycles.
- R5: In quadrature mode, the first word taken with txEn high after an idle or a finished pair becomes I, and the next becomes Q. sampleValid pulses for one cycle, in the cycle after the Q transfer, and iOut and qOut then hold that pair.
- R6: A transfer taken with txEn low discards any partial pair or partial serial word and gives no sampleValid. Outputs keep their previous values. The next transfer with txEn high starts a new sample.
- R7: In real mode, each transfer with txEn high gives sampleValid in the next cycle, with iOut equal to the word and qOut equal to 0.
- R8: In serial mode, bit 0 of dataIn carries I and bit 1 carries Q, most significant bit first. After the 16th bit, sampleValid pulses and both words appear sign-extended to 18 bits.
- R9: In serial mode, dataIn[17:2] has no effect on the outputs.
- R10: Any change of mode, R or rateCtl restarts the divider. dataClkEn stays low in the cycle of the change, and the first enable comes exactly one full divisor period later.
- R11: Within each divisor period, dataClkOut is low for the first floor(div/2) cycles and high for the rest. dataClkEn falls in the last cycle of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Input format select |
| rateR | input | 6 | Rate value R |
| rateCtl | input | 1 | Doubles the quadrature-mode divisor |
| txEn | input | 1 | Frames the input stream |
| dataIn | input | 18 | Parallel word, or serial bits on [1:0] |
| dataClkEn | output | 1 | One-cycle strobe marking each transfer |
| dataClkOut | output | 1 | Divided clock for the data source |
| sampleValid | output | 1 | One-cycle strobe when a sample is complete |
| iOut | output | 18 | In-phase word |
| qOut | output | 18 | Quadrature word |

## Verification
The divider is checked under several settings:

- Quadrature mode with rateCtl low, including R = 0 and R = 3.
- Quadrature mode with rateCtl high.
- Real mode with rateCtl both low and high, which shows that real mode ignores rateCtl.
- Serial mode.

Each setting measures the first gap after a configuration change and one steady period.

Quadrature pairs use distinct I and Q values, so a swapped or shifted pairing shows up. Serial words use a negative I with a positive Q, and then the reverse, with the unused pins toggled, which exposes bit-order, sign-extension and pin-mapping faults. Frames cut off mid-pair and mid-word show whether a partial sample leaks into the output or throws off the count of the next one.

// File: rtl/iq_asm_pkg.sv
package iq_asm_pkg;
  typedef enum logic [1:0] {
    MODE_QUAD   = 2'b00,
    MODE_REAL   = 2'b01,
    MODE_SERIAL = 2'b10,
    MODE_QUAD_B = 2'b11
  } asmMode_e;

  typedef struct packed {
    logic loadI;
    logic loadQ;
    logic loadReal;
    logic shift;
    logic emit;
  } asmStrobe_t;
endpackage

// File: rtl/iqAsmCtrl.sv
module iqAsmCtrl
  import iq_asm_pkg::*;
#(
  parameter int RATE_W = 6,
  parameter int SER_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [RATE_W-1:0] rateR,
  input  logic              rateCtl,
  input  logic              txEn,
  output logic              dataClkEn,
  output logic              dataClkOut,
  output asmStrobe_t        strobe
);
  localparam int DIV_W = RATE_W + 2;
  localparam int CFG_W = RATE_W + 3;
  localparam int BIT_W = $clog2(SER_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SER_W - 1);

  logic [DIV_W-1:0] rEff, divisor, divCnt;
  logic [CFG_W-1:0] cfgNow, cfgPrev;
  logic             cfgChanged;
  logic             haveI;
  logic [BIT_W-1:0] bitCnt;

  assign cfgNow     = {mode, rateR, rateCtl};
  assign cfgChanged = (cfgNow != cfgPrev);

  always_comb begin
    rEff = {2'b00, rateR};
    if (rateR == '0) rEff = DIV_W'(1);
    unique case (mode)
      MODE_SERIAL: divisor = rEff;
      MODE_REAL:   divisor = rEff << 2;
      default:     divisor = rateCtl ? (rEff << 2) : (rEff << 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      cfgPrev <= '0;
    end else begin
      cfgPrev <= cfgNow;
      if (cfgChanged || divCnt == divisor - DIV_W'(1)) divCnt <= '0;
      else divCnt <= divCnt + DIV_W'(1);
    end
  end

  assign dataClkEn  = !cfgChanged && (divCnt == divisor - DIV_W'(1));
  assign dataClkOut = (divCnt >= (divisor >> 1));

  always_comb begin
    strobe = '0;
    if (dataClkEn && txEn) begin
      unique case (mode)
        MODE_SERIAL: begin
          strobe.shift = 1'b1;
          strobe.emit  = (bitCnt == LAST_BIT);
        end
        MODE_REAL: begin
          strobe.loadReal = 1'b1;
          strobe.emit     = 1'b1;
        end
        default: begin
          if (!haveI) strobe.loadI = 1'b1;
          else begin
            strobe.loadQ = 1'b1;
            strobe.emit  = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || cfgChanged) begin
      haveI  <= 1'b0;
      bitCnt <= '0;
    end else if (dataClkEn) begin
      if (!txEn) begin
        haveI  <= 1'b0;
        bitCnt <= '0;
      end else if (mode == MODE_SERIAL) begin
        bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + BIT_W'(1);
      end else if (mode != MODE_REAL) begin
        haveI <= !haveI;
      end
    end
  end

  // R2 R3 R4: counter stays inside the current period
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgChanged |-> divCnt < divisor);

  // R10: no enable right after a reload unless the period is one cycle
  p_reload_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgChanged) && divisor > DIV_W'(1)) |-> !dataClkEn);

  // R6: a dropped frame start never emits
  p_abort_no_emit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataClkEn && !txEn) |-> !strobe.emit);
endmodule

// File: rtl/iqAsmData.sv
module iqAsmData
  import iq_asm_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int SER_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  asmStrobe_t        strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic              sampleValid,
  output logic [DATA_W-1:0] iOut,
  output logic [DATA_W-1:0] qOut
);
  localparam int EXT_W = DATA_W - SER_W;

  logic [DATA_W-1:0] heldI;
  logic [SER_W-1:0]  shI, shQ, nextI, nextQ;

  assign nextI = {shI[SER_W-2:0], dataIn[0]};
  assign nextQ = {shQ[SER_W-2:0], dataIn[1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldI       <= '0;
      shI         <= '0;
      shQ         <= '0;
      iOut        <= '0;
      qOut        <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobe.emit;
      if (strobe.loadI) heldI <= dataIn;
      if (strobe.loadQ) begin
        iOut <= heldI;
        qOut <= dataIn;
      end
      if (strobe.loadReal) begin
        iOut <= dataIn;
        qOut <= '0;
      end
      if (strobe.shift) begin
        shI <= nextI;
        shQ <= nextQ;
        if (strobe.emit) begin
          iOut <= {{EXT_W{nextI[SER_W-1]}}, nextI};
          qOut <= {{EXT_W{nextQ[SER_W-1]}}, nextQ};
        end
      end
    end
  end

  // R5: Q output is the word on the bus at the Q transfer
  p_pair_q_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.loadQ) |-> qOut == $past(dataIn));

  // R7: real sample carries zero quadrature
  p_real_q_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.loadReal) |-> (qOut == '0 && iOut == $past(dataIn)));

  // R8: serial outputs are sign-extended
  p_serial_sext_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.shift && strobe.emit) |->
      ((iOut[DATA_W-1:SER_W-1] == '0 || iOut[DATA_W-1:SER_W-1] == '1) &&
       (qOut[DATA_W-1:SER_W-1] == '0 || qOut[DATA_W-1:SER_W-1] == '1)));
endmodule

// File: rtl/iqAssembler.sv
module iqAssembler
  import iq_asm_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int SER_W  = 16,
  parameter int RATE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [RATE_W-1:0] rateR,
  input  logic              rateCtl,
  input  logic              txEn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              dataClkEn,
  output logic              dataClkOut,
  output logic              sampleValid,
  output logic [DATA_W-1:0] iOut,
  output logic [DATA_W-1:0] qOut
);
  asmStrobe_t strobe;

  iqAsmCtrl #(.RATE_W(RATE_W), .SER_W(SER_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .rateR(rateR), .rateCtl(rateCtl),
    .txEn(txEn), .dataClkEn(dataClkEn), .dataClkOut(dataClkOut), .strobe(strobe)
  );

  iqAsmData #(.DATA_W(DATA_W), .SER_W(SER_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .sampleValid(sampleValid), .iOut(iOut), .qOut(qOut)
  );

  // R5: a sample only follows a framed transfer
  p_valid_after_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(dataClkEn && txEn));
endmodule

// File: tb/test_iqAssembler.sv
module test_iqAssembler;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  mode;
  logic [5:0]  rateR;
  logic        rateCtl;
  logic        txEn;
  logic [17:0] dataIn;
  logic        dataClkEn, dataClkOut, sampleValid;
  logic [17:0] iOut, qOut;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  iqAssembler i_iqAssembler (
    .clk(clk), .rstN(rstN), .mode(mode), .rateR(rateR), .rateCtl(rateCtl),
    .txEn(txEn), .dataIn(dataIn), .dataClkEn(dataClkEn), .dataClkOut(dataClkOut),
    .sampleValid(sampleValid), .iOut(iOut), .qOut(qOut)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitEn(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!dataClkEn && n < 2000);
  endtask

  task automatic setCfg(input logic [1:0] m, input logic [5:0] r, input logic rc);
    mode = m; rateR = r; rateCtl = rc;
  endtask

  task automatic sendWord(input logic en, input logic [17:0] d, output logic v);
    int n;
    waitEn(n);
    txEn = en; dataIn = d;
    @(negedge clk);
    v = sampleValid;
  endtask

  // R2 R3 R4 R10: first gap after a change and one steady period
  task automatic testPeriod(input string req, input logic [1:0] m, input logic [5:0] r,
                            input logic rc, input int expDiv);
    int n;
    @(negedge clk);
    setCfg(m, r, rc);
    check("R10", "no enable in change cycle", dataClkEn, 0);
    waitEn(n);
    check({req, " R10"}, "first gap", n, expDiv);
    waitEn(n);
    check(req, "period", n, expDiv);
  endtask

  // R11: clock output shape over one period of 6
  task automatic testClkShape();
    int n;
    @(negedge clk);
    setCfg(2'b00, 6'd3, 1'b0);
    waitEn(n);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R11", $sformatf("clk out at %0d", k), dataClkOut, (k >= 3) ? 1 : 0);
      check("R11", $sformatf("enable at %0d", k), dataClkEn, (k == 5) ? 1 : 0);
    end
  endtask

  // R5: quadrature pairing
  task automatic testQuad(input logic [17:0] iw, input logic [17:0] qw);
    logic v;
    sendWord(1'b1, iw, v);
    check("R5", "no valid after I", v, 0);
    sendWord(1'b1, qw, v);
    check("R5", "valid after Q", v, 1);
    check("R5", "I word", iOut, iw);
    check("R5", "Q word", qOut, qw);
    @(negedge clk);
    check("R5", "valid lasts one cycle", sampleValid, 0);
  endtask

  // R6: frame drop mid-pair
  task automatic testQuadAbort();
    logic v;
    logic [17:0] oldI, oldQ;
    oldI = iOut; oldQ = qOut;
    sendWord(1'b1, 18'h3_1111, v);
    sendWord(1'b0, 18'h0_2222, v);
    check("R6", "no valid on drop", v, 0);
    check("R6", "I held", iOut, oldI);
    check("R6", "Q held", qOut, oldQ);
    testQuad(18'h2_AAAA, 18'h1_5555);
  endtask

  // R7: real mode
  task automatic testReal(input logic [17:0] w);
    logic v;
    sendWord(1'b1, w, v);
    check("R7", "valid", v, 1);
    check("R7", "I real word", iOut, w);
    check("R7", "Q zero", qOut, 0);
  endtask

  // R8 R9: serial word
  task automatic testSerial(input logic [15:0] iw, input logic [15:0] qw, input logic [15:0] junk);
    logic v;
    int early = 0;
    for (int b = 15; b >= 0; b--) begin
      sendWord(1'b1, {junk ^ 16'(b * 16'h1357), qw[b], iw[b]}, v);
      if (b > 0 && v) early++;
    end
    check("R8", "no early valid", early, 0);
    check("R8", "valid after 16 bits", v, 1);
    check("R8 R9", "I sign-extended", iOut, {{2{iw[15]}}, iw});
    check("R8 R9", "Q sign-extended", qOut, {{2{qw[15]}}, qw});
  endtask

  // R6: serial drop mid-word
  task automatic testSerialAbort();
    logic v;
    int early = 0;
    for (int b = 0; b < 7; b++) begin
      sendWord(1'b1, 18'h3_FFFF, v);
      if (v) early++;
    end
    sendWord(1'b0, 18'h0, v);
    if (v) early++;
    check("R6", "no valid on serial drop", early, 0);
    testSerial(16'h1234, 16'hF00D, 16'hFFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; txEn = 1'b0; dataIn = '0;
    setCfg(2'b00, 6'd1, 1'b0);
    repeat (5) @(negedge clk);
    check("R1", "valid in reset", sampleValid, 0);
    check("R1", "I in reset", iOut, 0);
    check("R1", "Q in reset", qOut, 0);
    rstN = 1'b1;

    testPeriod("R2", 2'b00, 6'd3, 1'b0, 6);
    testPeriod("R2", 2'b00, 6'd0, 1'b0, 2);
    testPeriod("R3", 2'b00, 6'd2, 1'b1, 8);
    testPeriod("R3", 2'b01, 6'd3, 1'b0, 12);
    testPeriod("R3", 2'b01, 6'd3, 1'b1, 12);
    testPeriod("R4", 2'b10, 6'd5, 1'b0, 5);
    testPeriod("R2", 2'b11, 6'd2, 1'b0, 4);
    testClkShape();

    @(negedge clk); setCfg(2'b00, 6'd2, 1'b0);
    testQuad(18'h1_2345, 18'h2_ABCD);
    testQuad(18'h3_FFFF, 18'h0_0001);
    testQuadAbort();
    txEn = 1'b0;

    @(negedge clk); setCfg(2'b01, 6'd1, 1'b0);
    testReal(18'h2_5A5A);
    testReal(18'h1_0F0F);
    txEn = 1'b0;

    @(negedge clk); setCfg(2'b10, 6'd2, 1'b0);
    testSerial(16'h8421, 16'h7BDE, 16'hA5C3);
    testSerial(16'h0F0F, 16'hC001, 16'h5A3C);
    testSerialAbort();
    txEn = 1'b0;

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule